// File: doc/BRIEF.md
# Stream Encoder Power-Up Sequencer

This block is the control sequencer that walks a video stream encoder through its bring-up and tear-down. Five one-cycle command pulses reach it from a control plane:

- **enable** powers up the encoder core.
- **unblank** starts video and brings both FIFOs out of reset.
- **blank** stops video and the FIFOs.
- **disable** powers the core down.
- **packet-on** turns on the secondary-packet path.

Each command runs as a fixed sequence of steps, one control output per step. The block drives the encoder clock enable, the core reset and core enable, the video enable, the reset and enable of the pixel FIFO and the ramp FIFO, the CRC enable and the packet-path enable. The FIFOs, the CRC engine and the datapath live outside the block. Only their control and acknowledge wires connect here.

Three targets have a reset: the core, the pixel FIFO and the ramp FIFO. Each reset is a two-phase request/acknowledge exchange:

1. The sequencer raises the reset and polls the target's acknowledge until it reads high.
2. It drops the reset and polls until the acknowledge reads low.

Polls are spaced by a parameterised prescaler (one microsecond at the default clock). A retry budget bounds each wait. When the budget runs out, the command is aborted and a sticky timeout flag is raised.

Top module: `strm_pwr_seq`

## Requirements
- R1: After reset, every control output, `busy`, `done` and `timeout` are 0, and `src_sel_o` is 0.
- R2: The enable command takes these steps in order. It sets `enc_clk_en`, then raises `core_rst` and waits for `core_rst_ack` to read 1. It then drops `core_rst` and waits for `core_rst_ack` to read 0. Only after that does it set `core_en`.
- R3: A handshake wait samples the acknowledge once every `POLL_DIV` cycles, first `POLL_DIV` cycles after the reset edge changes, for at most `MAX_POLLS` samples. With acknowledge latency L and no timeout, a step's wait ends on the first sample at or after L. A wait whose acknowledge never matches keeps `busy` high for exactly 2 + `POLL_DIV`*`MAX_POLLS` cycles, counted from the cycle after the enable command is sampled.
- R4: The unblank command latches `src_sel_i` into `src_sel_o` when the command is accepted. It then sets `vid_en`, runs the two-phase handshake on `pxf_rst`/`pxf_rst_ack`, and sets `pxf_en`.
- R5: Unblank then runs the two-phase handshake on `rmp_rst`/`rmp_rst_ack`, sets `crc_en`, and only after that sets `rmp_en`.
- R6: The blank command clears `vid_en`, `pkt_en`, `pxf_en` and `rmp_en`, one per cycle, in that order.
- R7: The disable command clears `core_en` and then clears `enc_clk_en`.
- R8: The packet-on command sets `pkt_en`.
- R9: When a wait exhausts its budget:
  - the command is aborted and the block returns to idle;
  - the reset output keeps its current level;
  - `timeout` rises and stays high until the next command is accepted;
  - no `done` pulse is given.
- R10: While `busy` is high, commands are ignored. Every command that completes gives exactly one one-cycle `done` pulse, in the cycle that `busy` falls.
- R11: When several commands arrive together, only one is taken. The priority, highest first, is enable, unblank, blank, disable, packet-on.
- R12: At most one of the ten control outputs changes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_enable | input | 1 | Power-up command pulse |
| cmd_unblank | input | 1 | Start-video command pulse |
| cmd_blank | input | 1 | Stop-video command pulse |
| cmd_disable | input | 1 | Power-down command pulse |
| cmd_pkt_on | input | 1 | Packet-path enable command pulse |
| src_sel_i | input | SRC_W | Pixel source select, latched by unblank |
| core_rst_ack | input | 1 | Core reset acknowledge |
| pxf_rst_ack | input | 1 | Pixel FIFO reset acknowledge |
| rmp_rst_ack | input | 1 | Ramp FIFO reset acknowledge |
| enc_clk_en | output | 1 | Encoder clock enable |
| core_rst | output | 1 | Core reset request |
| core_en | output | 1 | Core enable (idle pattern output) |
| vid_en | output | 1 | Video transmission enable |
| src_sel_o | output | SRC_W | Latched pixel source select |
| pxf_rst | output | 1 | Pixel FIFO reset request |
| pxf_en | output | 1 | Pixel FIFO enable |
| rmp_rst | output | 1 | Ramp FIFO reset request |
| rmp_en | output | 1 | Ramp FIFO enable |
| crc_en | output | 1 | Continuous CRC enable |
| pkt_en | output | 1 | Secondary-packet path enable |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| timeout | output | 1 | Sticky handshake timeout flag |

## Verification
Enable is run twice. In the first run the acknowledge arrives after a latency that forces one failed poll before a match. In the second run the acknowledge never rises. The two runs show the retry path apart from budget exhaustion, and the length of `busy` pins down the poll spacing in both cases.

Unblank, blank, disable and packet-on are each run from states in which some of their target bits are already at the final value. This shows that each step changes only its own output. Blank is also issued together with disable, and a disable is injected while a blank is still running. These two patterns separate priority from the busy-ignore rule.

After the timeout, a further enable is issued. This shows that the abandoned reset level carries over and that the flag clears when the next command is accepted.

// File: rtl/sps_pkg.sv
package sps_pkg;

   // Control vector bit positions (bench relies on this packing order)
   localparam int CTL_W    = 10;
   localparam int B_CLK    = 0;
   localparam int B_CRST   = 1;
   localparam int B_CEN    = 2;
   localparam int B_VID    = 3;
   localparam int B_PRST   = 4;
   localparam int B_PEN    = 5;
   localparam int B_RRST   = 6;
   localparam int B_REN    = 7;
   localparam int B_CRC    = 8;
   localparam int B_PKT    = 9;

   typedef enum logic [4:0] {
      ST_IDLE,
      ST_E_CLK, ST_E_RHI, ST_E_WHI, ST_E_RLO, ST_E_WLO, ST_E_EN,
      ST_U_VID, ST_U_PHI, ST_U_PWH, ST_U_PLO, ST_U_PWL, ST_U_PEN,
      ST_U_RHI, ST_U_RWH, ST_U_RLO, ST_U_RWL, ST_U_CRC, ST_U_REN,
      ST_B_VID, ST_B_PKT, ST_B_PEN, ST_B_REN,
      ST_D_CEN, ST_D_CLK,
      ST_P_PKT
   } seq_state_t;

   typedef enum logic [1:0] {
      TGT_CORE = 2'd0,
      TGT_PXF  = 2'd1,
      TGT_RMP  = 2'd2
   } hs_tgt_t;

endpackage

// File: rtl/sps_tick.sv
module sps_tick #(
   parameter int DIV = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("sps_tick: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_direct
         logic unused_clr;
         assign unused_clr = clr;
         assign tick       = run;
      end else begin : g_count
         localparam int PW = $clog2(DIV);
         logic [PW-1:0] pres_q;

         assign tick = run && (pres_q == PW'(DIV - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pres_q <= '0;
            end else if (clr) begin
               pres_q <= '0;
            end else if (run) begin
               pres_q <= tick ? '0 : pres_q + 1'b1;
            end
         end

         p_pres_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pres_q <= PW'(DIV - 1));
      end
   endgenerate

endmodule

// File: rtl/sps_handshake.sv
module sps_handshake
   import sps_pkg::*;
#(
   parameter int POLL_DIV  = 250,
   parameter int MAX_POLLS = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       want,
   input  hs_tgt_t    tgt,
   input  logic [2:0] acks,
   output logic       ok,
   output logic       fail
);

   localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

   generate
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("sps_handshake: MAX_POLLS must be at least 1");
      end
   endgenerate

   logic             act_q;
   logic             want_q;
   hs_tgt_t          tgt_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;
   logic             ack_sel;
   logic             match;
   logic             last;

   sps_tick #(.DIV(POLL_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .run   (act_q),
      .tick  (tick)
   );

   always_comb begin
      case (tgt_q)
         TGT_CORE: ack_sel = acks[0];
         TGT_PXF:  ack_sel = acks[1];
         TGT_RMP:  ack_sel = acks[2];
         default:  ack_sel = 1'b0;
      endcase
   end

   assign match = (ack_sel == want_q);
   assign last  = (cnt_q == CNT_W'(MAX_POLLS - 1));
   assign ok    = tick && match;
   assign fail  = tick && !match && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         want_q <= 1'b0;
         tgt_q  <= TGT_CORE;
         cnt_q  <= '0;
      end else if (start) begin
         act_q  <= 1'b1;
         want_q <= want;
         tgt_q  <= tgt;
         cnt_q  <= '0;
      end else if (tick) begin
         if (match || last) begin
            act_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   p_ok_fail_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok && fail));
   p_poll_only_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ok || fail) |-> act_q);
   p_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((ok || fail) && !start) |=> !act_q);

endmodule

// File: rtl/strm_pwr_seq.sv
module strm_pwr_seq
   import sps_pkg::*;
#(
   parameter int SRC_W     = 3,
   parameter int POLL_DIV  = 250,
   parameter int MAX_POLLS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_enable,
   input  logic             cmd_unblank,
   input  logic             cmd_blank,
   input  logic             cmd_disable,
   input  logic             cmd_pkt_on,
   input  logic [SRC_W-1:0] src_sel_i,
   input  logic             core_rst_ack,
   input  logic             pxf_rst_ack,
   input  logic             rmp_rst_ack,
   output logic             enc_clk_en,
   output logic             core_rst,
   output logic             core_en,
   output logic             vid_en,
   output logic [SRC_W-1:0] src_sel_o,
   output logic             pxf_rst,
   output logic             pxf_en,
   output logic             rmp_rst,
   output logic             rmp_en,
   output logic             crc_en,
   output logic             pkt_en,
   output logic             busy,
   output logic             done,
   output logic             timeout
);

   generate
      if (SRC_W < 1) begin : g_bad_src
         $error("strm_pwr_seq: SRC_W must be at least 1");
      end
   endgenerate

   seq_state_t       st_q;
   logic [CTL_W-1:0] ctl_q;
   logic [SRC_W-1:0] src_q;
   logic             done_q;
   logic             to_q;

   logic             hs_start;
   logic             hs_want;
   hs_tgt_t          hs_tgt;
   logic             hs_ok;
   logic             hs_fail;
   logic             any_cmd;

   assign any_cmd = cmd_enable | cmd_unblank | cmd_blank | cmd_disable | cmd_pkt_on;

   // Handshake launch decode: one step state per reset edge
   always_comb begin
      hs_start = 1'b1;
      hs_want  = 1'b1;
      hs_tgt   = TGT_CORE;
      case (st_q)
         ST_E_RHI: begin hs_want = 1'b1; hs_tgt = TGT_CORE; end
         ST_E_RLO: begin hs_want = 1'b0; hs_tgt = TGT_CORE; end
         ST_U_PHI: begin hs_want = 1'b1; hs_tgt = TGT_PXF;  end
         ST_U_PLO: begin hs_want = 1'b0; hs_tgt = TGT_PXF;  end
         ST_U_RHI: begin hs_want = 1'b1; hs_tgt = TGT_RMP;  end
         ST_U_RLO: begin hs_want = 1'b0; hs_tgt = TGT_RMP;  end
         default:  hs_start = 1'b0;
      endcase
   end

   sps_handshake #(
      .POLL_DIV  (POLL_DIV),
      .MAX_POLLS (MAX_POLLS)
   ) u_hs (
      .clk   (clk),
      .rst_n (rst_n),
      .start (hs_start),
      .want  (hs_want),
      .tgt   (hs_tgt),
      .acks  ({rmp_rst_ack, pxf_rst_ack, core_rst_ack}),
      .ok    (hs_ok),
      .fail  (hs_fail)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ctl_q  <= '0;
         src_q  <= '0;
         done_q <= 1'b0;
         to_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (any_cmd) to_q <= 1'b0;
               if (cmd_enable)       st_q <= ST_E_CLK;
               else if (cmd_unblank) begin
                  st_q  <= ST_U_VID;
                  src_q <= src_sel_i;
               end
               else if (cmd_blank)   st_q <= ST_B_VID;
               else if (cmd_disable) st_q <= ST_D_CEN;
               else if (cmd_pkt_on)  st_q <= ST_P_PKT;
            end
            // power-up
            ST_E_CLK: begin ctl_q[B_CLK]  <= 1'b1; st_q <= ST_E_RHI; end
            ST_E_RHI: begin ctl_q[B_CRST] <= 1'b1; st_q <= ST_E_WHI; end
            ST_E_WHI: begin
               if (hs_ok)        st_q <= ST_E_RLO;
               else if (hs_fail) begin st_q <= ST_IDLE; to_q <= 1'b1; end
            end
            ST_E_RLO: begin ctl_q[B_CRST] <= 1'b0; st_q <= ST_E_WLO; end
            ST_E_WLO: begin
               if (hs_ok)        st_q <= ST_E_EN;
               else if (hs_fail) begin st_q <= ST_IDLE; to_q <= 1'b1; end
            end
            ST_E_EN: begin
               ctl_q[B_CEN] <= 1'b1; st_q <= ST_IDLE; done_q <= 1'b1;
            end
            // start video
            ST_U_VID: begin ctl_q[B_VID]  <= 1'b1; st_q <= ST_U_PHI; end
            ST_U_PHI: begin ctl_q[B_PRST] <= 1'b1; st_q <= ST_U_PWH; end
            ST_U_PWH: begin
               if (hs_ok)        st_q <= ST_U_PLO;
               else if (hs_fail) begin st_q <= ST_IDLE; to_q <= 1'b1; end
            end
            ST_U_PLO: begin ctl_q[B_PRST] <= 1'b0; st_q <= ST_U_PWL; end
            ST_U_PWL: begin
               if (hs_ok)        st_q <= ST_U_PEN;
               else if (hs_fail) begin st_q <= ST_IDLE; to_q <= 1'b1; end
            end
            ST_U_PEN: begin ctl_q[B_PEN]  <= 1'b1; st_q <= ST_U_RHI; end
            ST_U_RHI: begin ctl_q[B_RRST] <= 1'b1; st_q <= ST_U_RWH; end
            ST_U_RWH: begin
               if (hs_ok)        st_q <= ST_U_RLO;
               else if (hs_fail) begin st_q <= ST_IDLE; to_q <= 1'b1; end
            end
            ST_U_RLO: begin ctl_q[B_RRST] <= 1'b0; st_q <= ST_U_RWL; end
            ST_U_RWL: begin
               if (hs_ok)        st_q <= ST_U_CRC;
               else if (hs_fail) begin st_q <= ST_IDLE; to_q <= 1'b1; end
            end
            ST_U_CRC: begin ctl_q[B_CRC] <= 1'b1; st_q <= ST_U_REN; end
            ST_U_REN: begin
               ctl_q[B_REN] <= 1'b1; st_q <= ST_IDLE; done_q <= 1'b1;
            end
            // stop video
            ST_B_VID: begin ctl_q[B_VID] <= 1'b0; st_q <= ST_B_PKT; end
            ST_B_PKT: begin ctl_q[B_PKT] <= 1'b0; st_q <= ST_B_PEN; end
            ST_B_PEN: begin ctl_q[B_PEN] <= 1'b0; st_q <= ST_B_REN; end
            ST_B_REN: begin
               ctl_q[B_REN] <= 1'b0; st_q <= ST_IDLE; done_q <= 1'b1;
            end
            // power-down
            ST_D_CEN: begin ctl_q[B_CEN] <= 1'b0; st_q <= ST_D_CLK; end
            ST_D_CLK: begin
               ctl_q[B_CLK] <= 1'b0; st_q <= ST_IDLE; done_q <= 1'b1;
            end
            // packet path
            ST_P_PKT: begin
               ctl_q[B_PKT] <= 1'b1; st_q <= ST_IDLE; done_q <= 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign enc_clk_en = ctl_q[B_CLK];
   assign core_rst   = ctl_q[B_CRST];
   assign core_en    = ctl_q[B_CEN];
   assign vid_en     = ctl_q[B_VID];
   assign pxf_rst    = ctl_q[B_PRST];
   assign pxf_en     = ctl_q[B_PEN];
   assign rmp_rst    = ctl_q[B_RRST];
   assign rmp_en     = ctl_q[B_REN];
   assign crc_en     = ctl_q[B_CRC];
   assign pkt_en     = ctl_q[B_PKT];
   assign src_sel_o  = src_q;
   assign busy       = (st_q != ST_IDLE);
   assign done       = done_q;
   assign timeout    = to_q;

   p_one_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ctl_q ^ $past(ctl_q)) <= 1);
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !any_cmd) |=> $stable(ctl_q));
   p_core_needs_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_en) |-> enc_clk_en && !core_rst);
   p_rmp_after_crc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rmp_en) |-> crc_en);
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> !busy && !done);
   p_clk_off_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(enc_clk_en) |-> !core_en);

endmodule

// File: tb/strm_pwr_seq_bench.sv
module strm_pwr_seq_bench;
   localparam int SW  = 3;
   localparam int DIV = 4;
   localparam int NP  = 3;
   localparam int LAT = 5;
   // control vector packing: [0]clk [1]core_rst [2]core_en [3]vid [4]pxf_rst
   // [5]pxf_en [6]rmp_rst [7]rmp_en [8]crc [9]pkt
   localparam int I_CLK = 0, I_CRST = 1, I_CEN = 2, I_VID = 3, I_PRST = 4;
   localparam int I_PEN = 5, I_RRST = 6, I_REN = 7, I_CRC = 8, I_PKT = 9;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n;
   logic c_en = 0, c_ub = 0, c_bl = 0, c_di = 0, c_pk = 0;
   logic [SW-1:0] src_i = '0;
   logic core_ack, pxf_ack, rmp_ack;
   logic enc_clk_en, core_rst, core_en, vid_en, pxf_rst, pxf_en, rmp_rst, rmp_en, crc_en, pkt_en;
   logic [SW-1:0] src_o;
   logic busy, done, timeout;

   strm_pwr_seq #(.SRC_W(SW), .POLL_DIV(DIV), .MAX_POLLS(NP)) u_strm_pwr_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_enable(c_en), .cmd_unblank(c_ub), .cmd_blank(c_bl),
      .cmd_disable(c_di), .cmd_pkt_on(c_pk), .src_sel_i(src_i),
      .core_rst_ack(core_ack), .pxf_rst_ack(pxf_ack), .rmp_rst_ack(rmp_ack),
      .enc_clk_en(enc_clk_en), .core_rst(core_rst), .core_en(core_en),
      .vid_en(vid_en), .src_sel_o(src_o), .pxf_rst(pxf_rst), .pxf_en(pxf_en),
      .rmp_rst(rmp_rst), .rmp_en(rmp_en), .crc_en(crc_en), .pkt_en(pkt_en),
      .busy(busy), .done(done), .timeout(timeout)
   );

   // Acknowledge model: each ack follows its reset after LAT edges
   logic [LAT-1:0] sh_core = '0, sh_pxf = '0, sh_rmp = '0;
   bit stuck_core = 0;
   always @(posedge clk) begin
      sh_core <= {sh_core[LAT-2:0], core_rst};
      sh_pxf  <= {sh_pxf[LAT-2:0],  pxf_rst};
      sh_rmp  <= {sh_rmp[LAT-2:0],  rmp_rst};
   end
   assign core_ack = stuck_core ? 1'b0 : sh_core[LAT-1];
   assign pxf_ack  = sh_pxf[LAT-1];
   assign rmp_ack  = sh_rmp[LAT-1];

   logic [9:0] vec;
   assign vec = {pkt_en, crc_en, rmp_en, rmp_rst, pxf_en, pxf_rst, vid_en, core_en, core_rst, enc_clk_en};

   int checks = 0, errors = 0;
   logic [9:0] model = '0;
   logic [9:0] exp_q[$];
   logic [9:0] last_vec = '0;
   string cur_req = "R1";
   int done_seen = 0;
   bit mon_on = 0;

   // Monitor: every change of the control vector pops one expected snapshot
   always @(negedge clk) begin
      if (mon_on) begin
         if (done) done_seen++;
         if (vec !== last_vec) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL %s unexpected step actual=%b expected=%b", cur_req, vec, last_vec);
            end else begin
               if (exp_q[0] !== vec) begin
                  errors++;
                  $display("FAIL %s step order actual=%b expected=%b", cur_req, vec, exp_q[0]);
               end
               void'(exp_q.pop_front());
            end
            last_vec = vec;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic step(input int idx, input bit v);
      logic [9:0] nv;
      nv = model;
      nv[idx] = v;
      if (nv != model) exp_q.push_back(nv);
      model = nv;
   endtask

   task automatic set_cmd(input int c, input logic v);
      case (c)
         1: c_en = v;
         2: c_ub = v;
         3: c_bl = v;
         4: c_di = v;
         5: c_pk = v;
         6: begin c_bl = v; c_di = v; end
         default: ;
      endcase
   endtask

   task automatic fire(input int c, input logic [SW-1:0] s, input int extra, output int bcyc);
      done_seen = 0;
      @(negedge clk);
      src_i = s;
      set_cmd(c, 1'b1);
      @(negedge clk);
      set_cmd(c, 1'b0);
      src_i = ~s;
      bcyc = 0;
      while (busy && bcyc < 2000) begin
         bcyc++;
         if (bcyc == 2) set_cmd(extra, 1'b1);
         if (bcyc == 3) set_cmd(extra, 1'b0);
         @(negedge clk);
      end
      set_cmd(extra, 1'b0);
   endtask

   task automatic settle(input string rq, input int exp_done);
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, rq, "pending steps", exp_q.size(), 0);
      chk(vec === model, rq, "control vector", int'(vec), int'(model));
      chk(done_seen == exp_done, rq, "done pulses", done_seen, exp_done);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int b;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(vec == '0, "R1", "controls", int'(vec), 0);
      chk(!busy && !done && !timeout, "R1", "status", int'({busy, done, timeout}), 0);
      chk(src_o == '0, "R1", "src_sel_o", int'(src_o), 0);
      mon_on = 1;

      // R2 enable with one failed poll before the match (R3 spacing)
      cur_req = "R2";
      step(I_CLK, 1); step(I_CRST, 1); step(I_CRST, 0); step(I_CEN, 1);
      fire(1, '0, 0, b);
      chk(b == 20, "R3", "busy cycles with retry", b, 20);
      settle("R2", 1);

      // R4/R5 unblank
      cur_req = "R4";
      step(I_VID, 1); step(I_PRST, 1); step(I_PRST, 0); step(I_PEN, 1);
      step(I_RRST, 1); step(I_RRST, 0); step(I_CRC, 1); step(I_REN, 1);
      fire(2, 3'd5, 0, b);
      settle("R5", 1);
      chk(src_o == 3'd5, "R4", "latched source", int'(src_o), 5);

      // R8 packet path on
      cur_req = "R8";
      step(I_PKT, 1);
      fire(5, '0, 0, b);
      settle("R8", 1);

      // R6 blank, with a disable injected while busy (R10 ignore)
      cur_req = "R6";
      step(I_VID, 0); step(I_PKT, 0); step(I_PEN, 0); step(I_REN, 0);
      fire(3, '0, 4, b);
      settle("R6", 1);
      chk(core_en && enc_clk_en, "R10", "core still on after ignored disable",
          int'({core_en, enc_clk_en}), 3);

      // R11 priority: unblank again, packet on, then blank+disable together
      cur_req = "R11";
      step(I_VID, 1); step(I_PRST, 1); step(I_PRST, 0); step(I_PEN, 1);
      step(I_RRST, 1); step(I_RRST, 0); step(I_CRC, 1); step(I_REN, 1);
      fire(2, 3'd2, 0, b);
      settle("R11", 1);
      chk(src_o == 3'd2, "R4", "re-latched source", int'(src_o), 2);
      step(I_PKT, 1);
      fire(5, '0, 0, b);
      settle("R11", 1);
      step(I_VID, 0); step(I_PKT, 0); step(I_PEN, 0); step(I_REN, 0);
      fire(6, '0, 0, b);
      settle("R11", 1);
      chk(core_en == 1'b1, "R11", "blank beat disable", int'(core_en), 1);

      // R7 disable
      cur_req = "R7";
      step(I_CEN, 0); step(I_CLK, 0);
      fire(4, '0, 0, b);
      settle("R7", 1);

      // R9 timeout: acknowledge never rises
      cur_req = "R9";
      stuck_core = 1;
      step(I_CLK, 1); step(I_CRST, 1);
      fire(1, '0, 0, b);
      chk(b == 2 + DIV * NP, "R3", "busy cycles to timeout", b, 2 + DIV * NP);
      settle("R9", 0);
      chk(timeout == 1'b1, "R9", "timeout flag", int'(timeout), 1);
      chk(core_rst == 1'b1, "R9", "reset level kept", int'(core_rst), 1);
      repeat (5) @(negedge clk);
      chk(timeout == 1'b1, "R9", "timeout sticky", int'(timeout), 1);

      // Recovery: next enable clears the flag and finishes
      stuck_core = 0;
      step(I_CLK, 1); step(I_CRST, 1); step(I_CRST, 0); step(I_CEN, 1);
      fire(1, '0, 0, b);
      settle("R9", 1);
      chk(timeout == 1'b0, "R9", "flag cleared on accept", int'(timeout), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule